// File: doc/BRIEF.md
# Posted-Write Buffer with Tagged Address/Data Entries

This block sits between a processor core's store path and the master port of a system bus. It lets the core retire stores at once instead of waiting out the bus's wait states. A store that qualifies for posting is written into a shared queue. The store's start address occupies one tagged entry. Each of its data words occupies one further entry. A store of N words therefore costs N+1 entries. The drain side walks the queue and replays each store, one word per beat, over a simple valid/acknowledge port. It increments the address by four for every beat.

A store is posted only when two conditions hold. The buffer enable bit must be set, and the address must fall inside the bufferable window of the fixed address map. Any other store bypasses the queue, and so does any read. A bypassing operation does not reach the bus until every posted store ahead of it has drained, and it then completes word by word on the same port. The enable bit is cleared by reset, so after reset every write goes straight to the bus. The core presents one operation at a time with a valid/ready pair and holds it until it is accepted. The enable bit is only changed while no core operation is pending.

Top module: `mixed_wbuf`

## Requirements
- R1: After reset the bus port is idle (bus_valid low) and posting is off. Any write is then accepted (core_ready) only after all of its beats have been acknowledged on the bus.
- R2: A clock edge with ctl_we high loads ctl_bufen into the enable bit. While the bit is set, a bufferable write with room is accepted in its first cycle, before any bus beat. Clearing the bit makes writes unbuffered again.
- R3: With the default map a write is bufferable only when core_addr[31:30] == 2'b01. A write elsewhere is handled unbuffered even while posting is enabled.
- R4: The queue holds 12 entries. A write of N words (core_len = N, 1 to 4) takes N+1 entries. It is accepted only when at least N+1 entries are free, and otherwise core_ready stays low.
- R5: Each posted store is replayed in push order as N beats with bus_write high. Beat k carries address core_addr+4k and data core_wdata[32k+:32]. bus_last is high only on beat N-1.
- R6: While bus_valid is high and bus_ack is low, bus_addr, bus_wdata, bus_write and bus_last hold their values.
- R7: A read, or an unbuffered write, puts no beat on the bus while any posted entry remains in the queue.
- R8: Unbuffered writes and reads run as beats laid out as in R5, taken from the held core inputs. core_ready rises in the cycle the last beat is acknowledged. Each acknowledged read beat passes bus_rdata to core_rdata with core_rd_valid high.
- R9: A stalled posted write is accepted once the drain side frees enough entries. Entries are freed when the last beat of the oldest store is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ctl_we | input | 1 | Load strobe for the posting enable bit |
| ctl_bufen | input | 1 | New value of the posting enable bit |
| core_valid | input | 1 | Core operation pending; held until core_ready |
| core_write | input | 1 | 1 = write, 0 = read |
| core_addr | input | 32 | Start byte address (word aligned) |
| core_len | input | 3 | Number of words, 1 to 4 |
| core_wdata | input | 128 | Write words, word k in bits [32k+:32] |
| core_ready | output | 1 | Operation accepted or completed this cycle |
| core_rdata | output | 32 | Read data of the acknowledged beat |
| core_rd_valid | output | 1 | core_rdata valid this cycle |
| bus_valid | output | 1 | Beat request to the bus master |
| bus_write | output | 1 | Beat direction, 1 = write |
| bus_addr | output | 32 | Beat byte address |
| bus_wdata | output | 32 | Beat write data |
| bus_last | output | 1 | Final beat of the current operation |
| bus_ack | input | 1 | Beat accepted at this rising edge |
| bus_rdata | input | 32 | Read data for an acknowledged read beat |

## Verification
Four properties are checked on every cycle. The beat outputs must hold steady under back-pressure. The fill level must never pass capacity. A read beat must never appear while posted entries remain, and the port must stay quiet when nothing is queued and the core is idle. Other behaviours depend on whole sequences and are shown only by the directed scenarios: posting versus write-through after reset and across the enable and region cases, the exact entry cost of bursts when the queue fills, the stall and later release of a store, the replayed address and data order, and the placement of reads and unbuffered writes behind earlier posted stores.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  localparam int WORD_W = 32;

  // One queue slot: tag set marks a store's start address, clear marks a data word
  typedef struct packed {
    logic              is_addr;
    logic [WORD_W-1:0] word;
  } wb_ent_t;
endpackage

// File: rtl/wbuf_rst_sync.sv
module wbuf_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/wbuf_region.sv
module wbuf_region #(
  parameter int          ADDR_W = 32,
  parameter logic [31:0] MASK   = 32'hC000_0000,
  parameter logic [31:0] BASE   = 32'h4000_0000
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              in_region
);
  assign in_region = ((addr & MASK[ADDR_W-1:0]) == BASE[ADDR_W-1:0]);
endmodule

// File: rtl/wbuf_fifo.sv
module wbuf_fifo
  import wbuf_pkg::*;
#(
  parameter int DEPTH = 12,
  parameter int NPUSH = 5,
  parameter int NPEEK = 6,
  parameter int CNT_W = $clog2(DEPTH + 1),
  parameter int NW    = $clog2(NPUSH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NW-1:0]       push_n,
  input  wb_ent_t [NPUSH-1:0] push_ent,
  input  logic [NW-1:0]       pop_n,
  output logic [CNT_W-1:0]    fill,
  output wb_ent_t [NPEEK-1:0] peek
);
  localparam int PTR_W = $clog2(DEPTH);

  wb_ent_t          mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] fill_q, fill_d;
  logic [DEPTH-1:0] slot_we;
  wb_ent_t          slot_wd [DEPTH];

  function automatic logic [PTR_W-1:0] wrap(input logic [PTR_W-1:0] base, input int off);
    int s;
    s = int'(base) + off;
    if (s >= DEPTH) s = s - DEPTH;
    return PTR_W'(s);
  endfunction

  // Scatter up to NPUSH new entries into consecutive slots
  always_comb begin
    for (int s = 0; s < DEPTH; s++) begin
      slot_we[s] = 1'b0;
      slot_wd[s] = '0;
    end
    for (int j = 0; j < NPUSH; j++) begin
      if (NW'(j) < push_n) begin
        slot_we[wrap(wr_ptr_q, j)] = 1'b1;
        slot_wd[wrap(wr_ptr_q, j)] = push_ent[j];
      end
    end
  end

  always_comb begin
    wr_ptr_d = wrap(wr_ptr_q, int'(push_n));
    rd_ptr_d = wrap(rd_ptr_q, int'(pop_n));
    fill_d   = fill_q + CNT_W'(push_n) - CNT_W'(pop_n);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      fill_q   <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      fill_q   <= fill_d;
    end
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < DEPTH; s++) begin
      if (slot_we[s]) mem[s] <= slot_wd[s];
    end
  end

  always_comb begin
    for (int k = 0; k < NPEEK; k++) peek[k] = mem[wrap(rd_ptr_q, k)];
  end

  assign fill = fill_q;
endmodule

// File: rtl/wbuf_drain.sv
module wbuf_drain
  import wbuf_pkg::*;
#(
  parameter int MAX_BURST = 4,
  parameter int CNT_W     = 4,
  parameter int LEN_W     = $clog2(MAX_BURST + 1),
  parameter int NW        = $clog2(MAX_BURST + 2),
  parameter int NPEEK     = MAX_BURST + 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [CNT_W-1:0]              fill,
  input  wb_ent_t [NPEEK-1:0]           peek,
  input  logic                          dir_req,
  input  logic                          dir_write,
  input  logic [WORD_W-1:0]             dir_addr,
  input  logic [LEN_W-1:0]              dir_len,
  input  logic [MAX_BURST*WORD_W-1:0]   dir_wdata,
  input  logic                          bus_ack,
  output logic                          bus_valid,
  output logic                          bus_write,
  output logic [WORD_W-1:0]             bus_addr,
  output logic [WORD_W-1:0]             bus_wdata,
  output logic                          bus_last,
  output logic [NW-1:0]                 pop_n,
  output logic                          dir_done
);
  localparam int IDX_W = (MAX_BURST > 1) ? $clog2(MAX_BURST) : 1;

  logic [IDX_W-1:0] beat_q, beat_d;
  logic             beat_en;
  logic             buf_mode, dir_mode;
  int               nxt;

  always_comb begin
    buf_mode  = (fill != '0);
    dir_mode  = !buf_mode && dir_req;
    nxt       = int'(beat_q) + 2;
    bus_valid = 1'b0;
    bus_write = 1'b0;
    bus_addr  = '0;
    bus_wdata = '0;
    bus_last  = 1'b0;
    pop_n     = '0;
    dir_done  = 1'b0;
    if (buf_mode) begin
      // Head entry is a start address; the store ends at the next address tag or the fill level
      bus_valid = 1'b1;
      bus_write = 1'b1;
      bus_addr  = peek[0].word + (WORD_W'(beat_q) << 2);
      bus_wdata = peek[int'(beat_q) + 1].word;
      bus_last  = (nxt >= int'(fill)) || peek[nxt].is_addr;
      if (bus_ack && bus_last) pop_n = NW'(nxt);
    end else if (dir_mode) begin
      bus_valid = 1'b1;
      bus_write = dir_write;
      bus_addr  = dir_addr + (WORD_W'(beat_q) << 2);
      bus_wdata = dir_wdata[int'(beat_q)*WORD_W +: WORD_W];
      bus_last  = (int'(beat_q) + 1 >= int'(dir_len));
      dir_done  = bus_ack && bus_last;
    end
    beat_en = bus_valid && bus_ack;
    beat_d  = bus_last ? '0 : beat_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       beat_q <= '0;
    else if (beat_en) beat_q <= beat_d;
  end
endmodule

// File: rtl/mixed_wbuf.sv
module mixed_wbuf
  import wbuf_pkg::*;
#(
  parameter int          DEPTH       = 12,
  parameter int          MAX_BURST   = 4,
  parameter logic [31:0] REGION_MASK = 32'hC000_0000,
  parameter logic [31:0] REGION_BASE = 32'h4000_0000,
  localparam int         LEN_W       = $clog2(MAX_BURST + 1),
  localparam int         WDATA_W     = MAX_BURST * WORD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctl_we,
  input  logic               ctl_bufen,
  input  logic               core_valid,
  input  logic               core_write,
  input  logic [WORD_W-1:0]  core_addr,
  input  logic [LEN_W-1:0]   core_len,
  input  logic [WDATA_W-1:0] core_wdata,
  output logic               core_ready,
  output logic [WORD_W-1:0]  core_rdata,
  output logic               core_rd_valid,
  output logic               bus_valid,
  output logic               bus_write,
  output logic [WORD_W-1:0]  bus_addr,
  output logic [WORD_W-1:0]  bus_wdata,
  output logic               bus_last,
  input  logic               bus_ack,
  input  logic [WORD_W-1:0]  bus_rdata
);
  localparam int NPUSH = MAX_BURST + 1;
  localparam int NPEEK = MAX_BURST + 2;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int NW    = $clog2(NPEEK);

  logic                rst_n_s;
  logic                bufen_q, bufen_d;
  logic                in_region, want_post, has_room, accept, dir_done;
  logic [CNT_W-1:0]    fifo_fill;
  logic [NW-1:0]       push_n, pop_n;
  wb_ent_t [NPUSH-1:0] push_ent;
  wb_ent_t [NPEEK-1:0] peek;

  wbuf_rst_sync u_rst (.clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_n_s));

  // Posting enable bit, cleared by reset
  assign bufen_d = ctl_bufen;
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)    bufen_q <= 1'b0;
    else if (ctl_we) bufen_q <= bufen_d;
  end

  wbuf_region #(.ADDR_W(WORD_W), .MASK(REGION_MASK), .BASE(REGION_BASE)) u_region (
    .addr(core_addr), .in_region(in_region)
  );

  always_comb begin
    want_post = core_valid && core_write && bufen_q && in_region;
    has_room  = (DEPTH - int'(fifo_fill)) >= (int'(core_len) + 1);
    accept    = want_post && has_room;
    push_n    = accept ? NW'(int'(core_len) + 1) : '0;
  end

  assign push_ent[0] = '{is_addr: 1'b1, word: core_addr};
  for (genvar g = 1; g < NPUSH; g++) begin : g_push
    assign push_ent[g] = '{is_addr: 1'b0, word: core_wdata[(g-1)*WORD_W +: WORD_W]};
  end

  wbuf_fifo #(.DEPTH(DEPTH), .NPUSH(NPUSH), .NPEEK(NPEEK), .CNT_W(CNT_W), .NW(NW)) u_fifo (
    .clk(clk), .rst_n(rst_n_s), .push_n(push_n), .push_ent(push_ent),
    .pop_n(pop_n), .fill(fifo_fill), .peek(peek)
  );

  wbuf_drain #(.MAX_BURST(MAX_BURST), .CNT_W(CNT_W), .LEN_W(LEN_W), .NW(NW), .NPEEK(NPEEK)) u_drain (
    .clk(clk), .rst_n(rst_n_s), .fill(fifo_fill), .peek(peek),
    .dir_req(core_valid && !want_post), .dir_write(core_write), .dir_addr(core_addr),
    .dir_len(core_len), .dir_wdata(core_wdata), .bus_ack(bus_ack),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_last(bus_last), .pop_n(pop_n), .dir_done(dir_done)
  );

  assign core_ready    = accept || dir_done;
  assign core_rdata    = bus_rdata;
  assign core_rd_valid = bus_valid && bus_ack && !bus_write;
endmodule

// File: rtl/mixed_wbuf_chk.sv
module mixed_wbuf_chk #(
  parameter int DEPTH = 12,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] fill,
  input logic             core_valid,
  input logic             bus_valid,
  input logic             bus_ack,
  input logic             bus_write,
  input logic [31:0]      bus_addr,
  input logic [31:0]      bus_wdata,
  input logic             bus_last
);
  p_beat_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ack) |=> (bus_valid && $stable(bus_addr) && $stable(bus_wdata)
                                 && $stable(bus_write) && $stable(bus_last)));

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fill) <= DEPTH);

  p_read_drained_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write) |-> (fill == '0));

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ((fill == '0) && !core_valid) |-> !bus_valid);
endmodule

bind mixed_wbuf mixed_wbuf_chk #(.DEPTH(DEPTH), .CNT_W($clog2(DEPTH + 1))) u_chk (
  .clk(clk), .rst_n(rst_n), .fill(fifo_fill), .core_valid(core_valid),
  .bus_valid(bus_valid), .bus_ack(bus_ack), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_last(bus_last)
);

// File: tb/mixed_wbuf_test.sv
module mixed_wbuf_test;
  localparam int CLK_PERIOD = 10;
  localparam int MB = 4;

  logic          clk, rst_n, ctl_we, ctl_bufen;
  logic          core_valid, core_write, core_ready, core_rd_valid;
  logic [31:0]   core_addr, core_rdata;
  logic [2:0]    core_len;
  logic [MB*32-1:0] core_wdata;
  logic          bus_valid, bus_write, bus_last, bus_ack;
  logic [31:0]   bus_addr, bus_wdata, bus_rdata;

  int checks = 0, errors = 0;
  int wait_cfg = 0, wcnt = 0, hold_bad = 0, log_n = 0;
  logic [31:0] hold_a, hold_d;
  logic [31:0] log_addr [0:63];
  logic [31:0] log_data [0:63];
  logic        log_last [0:63];
  logic        log_wr   [0:63];

  mixed_wbuf uut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_bufen(ctl_bufen),
    .core_valid(core_valid), .core_write(core_write), .core_addr(core_addr),
    .core_len(core_len), .core_wdata(core_wdata), .core_ready(core_ready),
    .core_rdata(core_rdata), .core_rd_valid(core_rd_valid),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_last(bus_last), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Bus slave model: decides the acknowledge half a cycle before each rising edge
  always @(negedge clk) begin
    if (bus_valid) begin
      if (wcnt == 0) begin
        hold_a = bus_addr;
        hold_d = bus_wdata;
      end else if (bus_addr != hold_a || bus_wdata != hold_d) begin
        hold_bad++;
      end
      bus_rdata = 32'hD00D_0000 ^ bus_addr;
      if (wcnt >= wait_cfg) begin
        bus_ack = 1'b1;
        if (log_n < 64) begin
          log_addr[log_n] = bus_addr;
          log_data[log_n] = bus_wdata;
          log_last[log_n] = bus_last;
          log_wr[log_n]   = bus_write;
        end
        log_n++;
        wcnt = 0;
      end else begin
        bus_ack = 1'b0;
        wcnt++;
      end
    end else begin
      bus_ack = 1'b0;
      wcnt = 0;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic set_bufen(input logic v);
    @(posedge clk); #1;
    ctl_we = 1'b1; ctl_bufen = v;
    @(posedge clk); #1;
    ctl_we = 1'b0;
  endtask

  task automatic do_op(input bit wr, input logic [31:0] addr, input int len,
                       input logic [MB*32-1:0] wd, output int waited,
                       output int log_at, output logic [31:0] rdata);
    @(posedge clk); #1;
    core_valid = 1'b1; core_write = wr; core_addr = addr;
    core_len = 3'(len); core_wdata = wd;
    waited = 0; log_at = -1; rdata = '0;
    forever begin
      @(negedge clk); #1;
      if (core_ready) begin
        log_at = log_n;
        rdata  = core_rdata;
        break;
      end
      waited++;
      if (waited > 3000) break;
    end
    @(posedge clk); #1;
    core_valid = 1'b0;
  endtask

  task automatic wait_log(input int n);
    for (int i = 0; i < 3000 && log_n < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(bus_valid == 1'b0, "R1", "bus idle after reset", 32'(bus_valid), 0);
    check(core_ready == 1'b0, "R1", "no ready after reset", 32'(core_ready), 0);
  endtask

  task automatic t_write_through();
    int w, la; logic [31:0] rd;
    wait_cfg = 3;
    do_op(1, 32'h4000_0010, 1, 128'h1111_1111, w, la, rd);
    check(la == 1, "R1", "write reached bus before ready", 32'(la), 1);
    check(w >= 3, "R1", "write waited for bus", 32'(w), 3);
    check(log_addr[0] == 32'h4000_0010 && log_data[0] == 32'h1111_1111 && log_last[0],
          "R1", "write-through beat", log_data[0], 32'h1111_1111);
  endtask

  task automatic t_post_single();
    int w, la, b; logic [31:0] rd;
    set_bufen(1'b1);
    wait_cfg = 3;
    b = log_n;
    do_op(1, 32'h4000_0020, 1, 128'h2222_2222, w, la, rd);
    check(w == 0, "R2", "posted write accepted at once", 32'(w), 0);
    check(la == b, "R2", "no beat before posted accept", 32'(la), 32'(b));
    wait_log(b + 1);
    check(log_addr[b] == 32'h4000_0020 && log_data[b] == 32'h2222_2222 && log_last[b] && log_wr[b],
          "R5", "posted single beat", log_addr[b], 32'h4000_0020);
  endtask

  task automatic t_region();
    int w, la, b; logic [31:0] rd;
    wait_cfg = 2;
    b = log_n;
    do_op(1, 32'h8000_0040, 1, 128'h3333_3333, w, la, rd);
    check(la == b + 1, "R3", "upper region write not posted", 32'(la), 32'(b + 1));
    do_op(1, 32'h0000_0040, 1, 128'h4444_4444, w, la, rd);
    check(la == b + 2, "R3", "low region write not posted", 32'(la), 32'(b + 2));
    b = log_n;
    do_op(1, 32'h8000_8000, 2, {32'hBB02, 32'hBB01}, w, la, rd);
    check(la == b + 2, "R8", "direct burst ready after last beat", 32'(la), 32'(b + 2));
    check(log_addr[b + 1] == 32'h8000_8004 && log_data[b + 1] == 32'hBB02 && log_last[b + 1]
          && !log_last[b], "R8", "direct burst beats", log_addr[b + 1], 32'h8000_8004);
  endtask

  task automatic t_burst();
    int w, la, b; logic [31:0] rd;
    wait_cfg = 1;
    b = log_n;
    do_op(1, 32'h4000_0100, 4, {32'hA3, 32'hA2, 32'hA1, 32'hA0}, w, la, rd);
    check(w == 0, "R4", "4-word store fits", 32'(w), 0);
    wait_log(b + 4);
    for (int k = 0; k < 4; k++) begin
      check(log_addr[b + k] == 32'h4000_0100 + 32'(4 * k) && log_data[b + k] == 32'hA0 + 32'(k)
            && log_last[b + k] == (k == 3) && log_wr[b + k],
            "R5", "burst beat", log_addr[b + k], 32'h4000_0100 + 32'(4 * k));
    end
  endtask

  task automatic t_full();
    int w, la, b; logic [31:0] rd;
    logic [31:0] exp_a [10];
    wait_cfg = 20;
    b = log_n;
    do_op(1, 32'h4000_1000, 4, {32'hC3, 32'hC2, 32'hC1, 32'hC0}, w, la, rd);
    check(w == 0, "R4", "first 4-word store (5 entries)", 32'(w), 0);
    do_op(1, 32'h4000_2000, 4, {32'hD3, 32'hD2, 32'hD1, 32'hD0}, w, la, rd);
    check(w == 0, "R4", "second 4-word store (10 entries)", 32'(w), 0);
    do_op(1, 32'h4000_3000, 1, 128'hE0, w, la, rd);
    check(w == 0, "R4", "single store fills to 12", 32'(w), 0);
    do_op(1, 32'h4000_4000, 1, 128'hF0, w, la, rd);
    check(w >= 60, "R4", "store stalls when full", 32'(w), 60);
    check(w <= 3000, "R9", "stalled store released", 32'(w), 3000);
    wait_log(b + 10);
    for (int k = 0; k < 4; k++) exp_a[k] = 32'h4000_1000 + 32'(4 * k);
    for (int k = 0; k < 4; k++) exp_a[4 + k] = 32'h4000_2000 + 32'(4 * k);
    exp_a[8] = 32'h4000_3000;
    exp_a[9] = 32'h4000_4000;
    for (int k = 0; k < 10; k++)
      check(log_addr[b + k] == exp_a[k], "R5", "push order on bus", log_addr[b + k], exp_a[k]);
  endtask

  task automatic t_ordering();
    int w, la, b; logic [31:0] rd;
    wait_cfg = 4;
    b = log_n;
    do_op(1, 32'h4000_5000, 2, {32'h52, 32'h51}, w, la, rd);
    do_op(0, 32'h0000_2000, 1, '0, w, la, rd);
    check(la == b + 3, "R7", "read after posted beats", 32'(la), 32'(b + 3));
    check(log_addr[b + 2] == 32'h0000_2000 && !log_wr[b + 2], "R7", "read beat placement",
          log_addr[b + 2], 32'h0000_2000);
    check(rd == (32'hD00D_0000 ^ 32'h0000_2000), "R8", "read data returned", rd,
          32'hD00D_0000 ^ 32'h0000_2000);
    b = log_n;
    do_op(1, 32'h4000_6000, 1, 128'h61, w, la, rd);
    do_op(1, 32'h8000_6000, 1, 128'h62, w, la, rd);
    check(log_addr[b] == 32'h4000_6000 && log_addr[b + 1] == 32'h8000_6000, "R7",
          "unbuffered write behind posted one", log_addr[b + 1], 32'h8000_6000);
  endtask

  task automatic t_disable();
    int w, la, b; logic [31:0] rd;
    set_bufen(1'b0);
    wait_cfg = 2;
    b = log_n;
    do_op(1, 32'h4000_7000, 1, 128'h71, w, la, rd);
    check(la == b + 1, "R2", "cleared enable writes through", 32'(la), 32'(b + 1));
    check(hold_bad == 0, "R6", "beat held during waits", 32'(hold_bad), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete, actual %0d expected 0", 1);
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; ctl_we = 1'b0; ctl_bufen = 1'b0;
    core_valid = 1'b0; core_write = 1'b0; core_addr = '0; core_len = '0; core_wdata = '0;
    bus_ack = 1'b0; bus_rdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    t_reset();
    t_write_through();
    t_post_single();
    t_region();
    t_burst();
    t_full();
    t_ordering();
    t_disable();
    repeat (5) @(posedge clk);
    summary();
    $finish;
  end
endmodule